// File: doc/BRIEF.md
# Skew-Tolerant Ethernet Frame Receiver

This block takes a receive stream of nibble pairs and pulls frames out of it. The stream carries one rising-edge nibble and one falling-edge nibble per clock, as delivered by an external double-data-rate capture stage on a 125 MHz receive path. The block has no data-valid or control input and does not need a preamble or start-of-frame byte. While idle it compares the last six bytes it has seen against a programmed destination MAC address. It runs that comparison under two byte alignments at once, because data-line skew can shift the nibble boundary by half a clock. The alignment that matches is kept for the rest of that frame.

After the destination the block consumes six source-address bytes, a two-byte big-endian payload length, that many payload bytes, and four FCS bytes. Payload bytes go out on a byte-wide memory write port. Each frame starts at the current 1024-byte slot base. An internal CRC32 is compared with the received FCS. On a good frame the block pulses `frame_ok`, increments a 10-bit frame counter and moves the slot base up by 1024. Neither stream has back-pressure: the nibble input must present a pair on every clock, and the memory port must accept a write in any cycle where `mem_we` is high.

Top module: `eth_skew_rx`

## Requirements
- R1: After synchronous active-high reset, `busy`, `mem_we` and `frame_ok` are 0, `pkt_count` is 0 and the slot base is 0.
- R2: In the normal alignment each clock forms the byte {`rx_fall`, `rx_rise`}. A destination sent this way is found without any preamble or start-of-frame byte.
- R3: In the late alignment each clock forms the byte {`rx_rise`, previous `rx_fall`}. A destination sent this way is also found, and the rest of that frame is assembled with the same alignment.
- R4: After the destination the block consumes, in order, 6 source bytes, a 2-byte length with the first byte most significant, exactly length payload bytes, and 4 FCS bytes.
- R5: Payload byte k is written through the registered port at address slot base + k, with one `mem_we` cycle per byte. A length of 0 writes nothing, and `mem_we` is only ever high while `busy` is high.
- R6: A length above 1024 writes only the first 1024 bytes, but the frame is still consumed to its end, so a frame sent right after it is received normally.
- R7: The CRC is the reflected 0x04C11DB7 polynomial, seeded with all ones and inverted at the end. It covers the destination, source, length and payload, and the FCS arrives least significant byte first. When it matches and the destination matches, `frame_ok` is high for exactly one cycle, `pkt_count` increments and the slot base rises by 1024.
- R8: A frame with a CRC mismatch gives no `frame_ok`, leaves `pkt_count` unchanged and leaves the slot base unchanged.
- R9: `waddr_clr` while not busy clears `pkt_count` and the slot base to 0. While busy it has no effect.
- R10: `busy` rises in the cycle after the last destination byte, stays high until the frame has been checked, and is low when `frame_ok` pulses.
- R11: A frame whose destination differs from `target_mac` causes no `busy` and no writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Receive clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_rise | input | 4 | Nibble captured on the rising edge |
| rx_fall | input | 4 | Nibble captured on the falling edge |
| target_mac | input | 48 | Destination address to hunt for; bits 47:40 are the first byte on the wire |
| waddr_clr | input | 1 | Clear slot base and frame counter while idle |
| mem_we | output | 1 | Payload byte write strobe |
| mem_addr | output | 16 | Payload byte write address |
| mem_data | output | 8 | Payload byte |
| busy | output | 1 | Frame in progress |
| pkt_count | output | 10 | Count of good frames |
| frame_ok | output | 1 | One-cycle good-frame pulse |

## Verification
The same frame content is sent once in each nibble alignment, with no preamble, so the test shows whether each alignment locks on its own and whether the latched choice is used to build the later bytes. A corrupted FCS, a foreign destination and a zero length separate the three ways a frame can end without a good result: written but not counted, never started, and counted with nothing written. An oversize length followed at once by a short frame shows that truncation limits only the writes and not how far into the stream the frame is consumed. A clear pulse sent mid-frame and another sent while idle show that the clear is honoured only outside a frame.

// File: rtl/eth_skew_rx_pkg.sv
package eth_skew_rx_pkg;

  typedef enum logic [2:0] {
    ST_HUNT,
    ST_SRC,
    ST_LEN,
    ST_PAY,
    ST_FCS,
    ST_CHECK
  } rx_state_t;

  localparam logic [31:0] CRC_POLY_REFL = 32'hEDB88320;

  // one byte through a reflected CRC32, least significant bit first
  function automatic logic [31:0] crc32_byte(input logic [31:0] c_in, input logic [7:0] b);
    logic [31:0] c;
    c = c_in ^ {24'd0, b};
    for (int i = 0; i < 8; i++) begin
      c = c[0] ? ((c >> 1) ^ CRC_POLY_REFL) : (c >> 1);
    end
    return c;
  endfunction

endpackage

// File: rtl/eth_skew_rx_align.sv
module eth_skew_rx_align (
  input  logic       clk,
  input  logic       rst,
  input  logic [3:0] rx_rise,
  input  logic [3:0] rx_fall,
  output logic [7:0] byte_norm,
  output logic [7:0] byte_late
);
  logic [3:0] fall_q;

  always_ff @(posedge clk) begin
    if (rst) fall_q <= '0;
    else     fall_q <= rx_fall;
  end

  assign byte_norm = {rx_fall, rx_rise};
  assign byte_late = {rx_rise, fall_q};
endmodule

// File: rtl/eth_skew_rx_hunt.sv
module eth_skew_rx_hunt #(
  parameter int MAC_BYTES = 6
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic [7:0]             byte_norm,
  input  logic [7:0]             byte_late,
  input  logic [MAC_BYTES*8-1:0] target,
  output logic                   hit,
  output logic                   hit_late
);
  localparam int W = MAC_BYTES * 8;

  logic [W-1:0] win_q   [2];
  logic [W-1:0] win_nxt [2];
  logic [1:0]   match;

  // one history window per candidate alignment
  for (genvar g = 0; g < 2; g++) begin : g_win
    assign win_nxt[g] = {win_q[g][W-9:0], (g == 0) ? byte_norm : byte_late};
    assign match[g]   = (win_nxt[g] == target);
    always_ff @(posedge clk) begin
      if (rst) win_q[g] <= '0;
      else     win_q[g] <= win_nxt[g];
    end
  end

  // normal alignment wins a tie
  assign hit      = |match;
  assign hit_late = match[1] & ~match[0];
endmodule

// File: rtl/eth_skew_rx_crc.sv
module eth_skew_rx_crc
  import eth_skew_rx_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        load,
  input  logic [31:0] load_val,
  input  logic        en,
  input  logic [7:0]  din,
  output logic [31:0] crc
);
  always_ff @(posedge clk) begin
    if (rst)       crc <= '1;
    else if (load) crc <= load_val;
    else if (en)   crc <= crc32_byte(crc, din);
  end
endmodule

// File: rtl/eth_skew_rx.sv
module eth_skew_rx
  import eth_skew_rx_pkg::*;
#(
  parameter int ADDR_W     = 16,
  parameter int SLOT_BYTES = 1024,
  parameter int CNT_W      = 10,
  parameter int LEN_W      = 16,
  parameter int MAC_BYTES  = 6
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic [3:0]             rx_rise,
  input  logic [3:0]             rx_fall,
  input  logic [MAC_BYTES*8-1:0] target_mac,
  input  logic                   waddr_clr,
  output logic                   mem_we,
  output logic [ADDR_W-1:0]      mem_addr,
  output logic [7:0]             mem_data,
  output logic                   busy,
  output logic [CNT_W-1:0]       pkt_count,
  output logic                   frame_ok
);
  localparam int MAC_W = MAC_BYTES * 8;
  localparam int SRC_LAST = MAC_BYTES - 1;
  localparam logic [LEN_W:0] SLOT_LIM = (LEN_W + 1)'(SLOT_BYTES);

  logic [7:0]  byte_norm, byte_late, cur_byte;
  logic        hit, hit_late;
  logic [31:0] crc, crc_seed;

  rx_state_t         state_q;
  logic              late_q;
  logic [LEN_W-1:0]  cnt_q, len_q;
  logic [31:0]       fcs_q;
  logic [MAC_W-1:0]  dest_q;
  logic [ADDR_W-1:0] base_q;
  logic [LEN_W-1:0]  len_nxt;

  eth_skew_rx_align u_align (
    .clk(clk), .rst(rst), .rx_rise(rx_rise), .rx_fall(rx_fall),
    .byte_norm(byte_norm), .byte_late(byte_late)
  );

  eth_skew_rx_hunt #(.MAC_BYTES(MAC_BYTES)) u_hunt (
    .clk(clk), .rst(rst), .byte_norm(byte_norm), .byte_late(byte_late),
    .target(target_mac), .hit(hit), .hit_late(hit_late)
  );

  // the matched destination bytes equal the target, so seed from it
  always_comb begin
    crc_seed = '1;
    for (int i = 0; i < MAC_BYTES; i++) begin
      crc_seed = crc32_byte(crc_seed, target_mac[MAC_W-1-8*i -: 8]);
    end
  end

  eth_skew_rx_crc u_crc (
    .clk(clk), .rst(rst),
    .load(state_q == ST_HUNT && hit), .load_val(crc_seed),
    .en(state_q == ST_SRC || state_q == ST_LEN || state_q == ST_PAY),
    .din(cur_byte), .crc(crc)
  );

  assign cur_byte = late_q ? byte_late : byte_norm;
  assign len_nxt  = {len_q[LEN_W-9:0], cur_byte};
  assign busy     = (state_q != ST_HUNT);

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q   <= ST_HUNT;
      late_q    <= 1'b0;
      cnt_q     <= '0;
      len_q     <= '0;
      fcs_q     <= '0;
      dest_q    <= '0;
      base_q    <= '0;
      pkt_count <= '0;
      frame_ok  <= 1'b0;
      mem_we    <= 1'b0;
      mem_addr  <= '0;
      mem_data  <= '0;
    end else begin
      frame_ok <= 1'b0;
      mem_we   <= 1'b0;
      unique case (state_q)
        ST_HUNT: begin
          if (waddr_clr) begin
            base_q    <= '0;
            pkt_count <= '0;
          end
          if (hit) begin
            state_q <= ST_SRC;
            late_q  <= hit_late;
            cnt_q   <= '0;
            dest_q  <= target_mac;
          end
        end
        ST_SRC: begin
          cnt_q <= cnt_q + LEN_W'(1);
          if (cnt_q == LEN_W'(SRC_LAST)) begin
            state_q <= ST_LEN;
            cnt_q   <= '0;
          end
        end
        ST_LEN: begin
          len_q <= len_nxt;
          cnt_q <= cnt_q + LEN_W'(1);
          if (cnt_q == LEN_W'(1)) begin
            cnt_q   <= '0;
            state_q <= (len_nxt == '0) ? ST_FCS : ST_PAY;
          end
        end
        ST_PAY: begin
          if ({1'b0, cnt_q} < SLOT_LIM) begin
            mem_we   <= 1'b1;
            mem_addr <= base_q + ADDR_W'(cnt_q);
            mem_data <= cur_byte;
          end
          cnt_q <= cnt_q + LEN_W'(1);
          if (cnt_q == len_q - LEN_W'(1)) begin
            cnt_q   <= '0;
            state_q <= ST_FCS;
          end
        end
        ST_FCS: begin
          fcs_q <= {cur_byte, fcs_q[31:8]};
          cnt_q <= cnt_q + LEN_W'(1);
          if (cnt_q == LEN_W'(3)) begin
            cnt_q   <= '0;
            state_q <= ST_CHECK;
          end
        end
        ST_CHECK: begin
          if ((~crc == fcs_q) && (dest_q == target_mac)) begin
            frame_ok  <= 1'b1;
            pkt_count <= pkt_count + CNT_W'(1);
            base_q    <= base_q + ADDR_W'(SLOT_BYTES);
          end
          state_q <= ST_HUNT;
          late_q  <= 1'b0;
          len_q   <= '0;
          fcs_q   <= '0;
          dest_q  <= '0;
        end
        default: state_q <= ST_HUNT;
      endcase
    end
  end
endmodule

// File: rtl/eth_skew_rx_chk.sv
module eth_skew_rx_chk #(
  parameter int CNT_W = 10
) (
  input logic             clk,
  input logic             rst,
  input logic             waddr_clr,
  input logic             mem_we,
  input logic             busy,
  input logic [CNT_W-1:0] pkt_count,
  input logic             frame_ok
);
  // R7
  ok_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    frame_ok |=> !frame_ok);

  // R7
  ok_count_chk: assert property (@(posedge clk) disable iff (rst)
    frame_ok |-> pkt_count == $past(pkt_count) + CNT_W'(1));

  // R8
  count_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (pkt_count != $past(pkt_count)) && !$past(waddr_clr) |-> frame_ok);

  // R9
  clr_idle_chk: assert property (@(posedge clk) disable iff (rst)
    (waddr_clr && !busy) |=> pkt_count == '0);

  // R5
  we_busy_chk: assert property (@(posedge clk) disable iff (rst)
    mem_we |-> busy);

  // R10
  ok_idle_chk: assert property (@(posedge clk) disable iff (rst)
    frame_ok |-> !busy);
endmodule

bind eth_skew_rx eth_skew_rx_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst(rst), .waddr_clr(waddr_clr), .mem_we(mem_we),
  .busy(busy), .pkt_count(pkt_count), .frame_ok(frame_ok)
);

// File: tb/eth_skew_rx_test.sv
module eth_skew_rx_test;
  localparam logic [47:0] TGT = 48'h02_11_22_33_44_55;
  localparam logic [47:0] SRC = 48'hA0_B1_C2_D3_E4_F5;
  localparam int LEAD = 4;
  localparam int TAIL = 8;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [3:0]  rx_rise = '0, rx_fall = '0;
  logic        waddr_clr = 1'b0;
  logic        mem_we, busy, frame_ok;
  logic [15:0] mem_addr;
  logic [7:0]  mem_data;
  logic [9:0]  pkt_count;

  int checks = 0, errors = 0;
  logic [7:0] fb [0:1199];
  int nbytes = 0;
  logic [7:0] exp_pay [0:1099];
  int mon_base = 0, mon_idx = 0, mon_bad = 0, ok_cnt = 0, ok_long = 0;
  bit busy_seen = 0, prev_ok = 0, done = 0;

  always #2 clk = ~clk;

  eth_skew_rx uut (
    .clk(clk), .rst(rst), .rx_rise(rx_rise), .rx_fall(rx_fall),
    .target_mac(TGT), .waddr_clr(waddr_clr), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_data(mem_data), .busy(busy),
    .pkt_count(pkt_count), .frame_ok(frame_ok)
  );

  always @(negedge clk) begin
    if (!rst) begin
      if (mem_we) begin
        if (int'(mem_addr) != mon_base + mon_idx || mon_idx > 1099 ||
            mem_data != exp_pay[mon_idx % 1100]) mon_bad++;
        mon_idx++;
      end
      if (frame_ok) ok_cnt++;
      if (frame_ok && prev_ok) ok_long++;
      if (busy) busy_seen = 1;
      prev_ok = frame_ok;
    end
  end

  task automatic check(input int act, input int exp, input string tag);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] crc_of(input int first, input int last);
    logic [31:0] c = 32'hFFFFFFFF;
    for (int i = first; i <= last; i++) begin
      c ^= {24'd0, fb[i]};
      for (int b = 0; b < 8; b++) c = c[0] ? ((c >> 1) ^ 32'hEDB88320) : (c >> 1);
    end
    return ~c;
  endfunction

  task automatic build(input logic [47:0] dest, input int len, input int seed, input bit bad);
    int p = 0;
    logic [31:0] f;
    for (int i = 0; i < LEAD; i++) fb[p++] = 8'h00;
    for (int i = 0; i < 6; i++) fb[p++] = dest[47-8*i -: 8];
    for (int i = 0; i < 6; i++) fb[p++] = SRC[47-8*i -: 8];
    fb[p++] = 8'(len >> 8);
    fb[p++] = 8'(len);
    for (int k = 0; k < len; k++) begin
      exp_pay[k % 1100] = 8'(seed + 7 * k);
      fb[p++] = 8'(seed + 7 * k);
    end
    f = crc_of(LEAD, p - 1);
    if (bad) f[0] = ~f[0];
    for (int i = 0; i < 4; i++) fb[p++] = f[8*i +: 8];
    for (int i = 0; i < TAIL; i++) fb[p++] = 8'h00;
    nbytes = p;
  endtask

  // clr_at < 0: no clear pulse during the frame
  task automatic send(input bit late, input int base, input int clr_at);
    mon_base = base; mon_idx = 0; mon_bad = 0; ok_cnt = 0; ok_long = 0; busy_seen = 0;
    for (int j = 0; j <= nbytes; j++) begin
      @(posedge clk); #1;
      waddr_clr = (j == clr_at);
      if (late) begin
        rx_rise = (j > 0) ? fb[j-1][7:4] : 4'h0;
        rx_fall = (j < nbytes) ? fb[j][3:0] : 4'h0;
      end else begin
        rx_rise = (j < nbytes) ? fb[j][3:0] : 4'h0;
        rx_fall = (j < nbytes) ? fb[j][7:4] : 4'h0;
      end
    end
    @(posedge clk); #1;
    waddr_clr = 1'b0; rx_rise = '0; rx_fall = '0;
    @(negedge clk);
  endtask

  task automatic t_reset;
    @(negedge clk);
    check(int'(busy), 0, "R1 busy");
    check(int'(mem_we), 0, "R1 mem_we");
    check(int'(frame_ok), 0, "R1 frame_ok");
    check(int'(pkt_count), 0, "R1 pkt_count");
  endtask

  task automatic t_normal;
    build(TGT, 8, 3, 0); send(0, 0, -1);
    check(ok_cnt, 1, "R2 R7 good pulse normal alignment");
    check(ok_long, 0, "R7 pulse width");
    check(mon_idx, 8, "R5 write count");
    check(mon_bad, 0, "R4 R5 payload address and data");
    check(int'(pkt_count), 1, "R7 count");
    check(int'(busy_seen), 1, "R10 busy during frame");
    check(int'(busy), 0, "R10 idle after frame");
  endtask

  task automatic t_late;
    build(TGT, 5, 40, 0); send(1, 1024, -1);
    check(ok_cnt, 1, "R3 good pulse late alignment");
    check(mon_idx, 5, "R3 write count");
    check(mon_bad, 0, "R3 R7 payload at next slot");
    check(int'(pkt_count), 2, "R3 count");
  endtask

  task automatic t_bad_crc;
    build(TGT, 4, 9, 1); send(0, 2048, -1);
    check(ok_cnt, 0, "R8 no pulse on bad CRC");
    check(int'(pkt_count), 2, "R8 count unchanged");
    check(mon_bad, 0, "R8 payload still written");
    build(TGT, 3, 77, 0); send(0, 2048, -1);
    check(mon_bad, 0, "R8 slot base not advanced");
    check(ok_cnt, 1, "R8 following good frame");
    check(int'(pkt_count), 3, "R8 count after good");
  endtask

  task automatic t_wrong_dest;
    build(48'h02_11_22_33_44_56, 4, 1, 0); send(0, 0, -1);
    check(int'(busy_seen), 0, "R11 no busy");
    check(mon_idx, 0, "R11 no writes");
    check(ok_cnt, 0, "R11 no pulse");
  endtask

  task automatic t_len0;
    build(TGT, 0, 0, 0); send(0, 3072, -1);
    check(mon_idx, 0, "R5 length zero writes nothing");
    check(ok_cnt, 1, "R4 length zero frame accepted");
    check(int'(pkt_count), 4, "R7 count len0");
  endtask

  task automatic t_big;
    build(TGT, 1030, 5, 0); send(0, 4096, -1);
    check(mon_idx, 1024, "R6 truncated write count");
    check(mon_bad, 0, "R6 truncated data");
    check(ok_cnt, 1, "R6 oversize frame accepted");
    build(TGT, 2, 200, 0); send(1, 5120, -1);
    check(ok_cnt, 1, "R6 next frame after oversize");
    check(mon_bad, 0, "R6 next frame data");
    check(int'(pkt_count), 6, "R6 count");
  endtask

  task automatic t_clr_busy;
    build(TGT, 6, 11, 0); send(0, 6144, LEAD + 9);
    check(int'(pkt_count), 7, "R9 clear ignored while busy");
    check(mon_bad, 0, "R9 base kept while busy");
    check(ok_cnt, 1, "R9 frame good despite clear");
  endtask

  task automatic t_clr_idle;
    @(posedge clk); #1 waddr_clr = 1'b1;
    @(posedge clk); #1 waddr_clr = 1'b0;
    @(negedge clk);
    check(int'(pkt_count), 0, "R9 clear while idle");
    build(TGT, 2, 60, 0); send(1, 0, -1);
    check(mon_bad, 0, "R9 slot base back at zero");
    check(int'(pkt_count), 1, "R9 count after clear");
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    t_reset();
    t_normal();
    t_late();
    t_bad_crc();
    t_wrong_dest();
    t_len0();
    t_big();
    t_clr_busy();
    t_clr_idle();
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(4 * 150000);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired actual 0 expected 1");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule